// File: doc/BRIEF.md
# Channel-Indexed Carrier Frequency Configurator

This block holds the carrier plan for an eighteen-channel multicarrier transceiver. Each channel has a master carrier and two side carriers that always sit one frequency code below and one code above the master. The host reaches the bank indirectly. It first loads a channel pointer. Later writes of a frequency code or a side-carrier enable then land on the channel that the pointer selects. A code of zero switches the channel off. Codes above the legal ceiling are refused, and a sticky error bit records the refusal.

Every accepted code or enable write starts a background scan. The scan visits one pair of channels per clock and looks for active channels whose codes sit closer together than their carriers allow. When it finds a clash, it raises a flag and reports the lower channel index of the first clashing pair it reaches. The block also drives a phase increment for each of the 54 carriers, for a phase accumulator clocked from a 10 MHz reference. Code k maps to (k+1) × 2^(W−11), so one code step equals 10 MHz / 2048.

Top module: `carrier_freq_bank`

## Requirements
- R1: After reset the pointer is 0, every code is 0, every side enable is 0, the error bit is 0, the scan is idle, the conflict flag is 0 and every carrier increment is 0.
- R2: A write with `wr_sel`=0 loads `wr_data` into the pointer if the value is 0 to 53. A larger value is ignored and the pointer keeps its value.
- R3: A write with `wr_sel`=1 stores `wr_data` (0 to 101) as the code of the channel at the pointer. `sel_code` shows the code of the pointed channel, and shows 0 when the pointer is 18 or more. `wr_sel`=3 has no effect.
- R4: A code write above 101 changes no code and sets `code_err`. Only reset clears `code_err`.
- R5: Code and enable writes made while the pointer is 18 to 53 change no channel.
- R6: A write with `wr_sel`=2 stores `wr_data[0]` as the side enable of the pointed channel. `sel_side` shows it, and shows 0 when the pointer is 18 or more.
- R7: Carrier c of channel n is at bits [(3n+c)·W +: W] of `carrier_inc`, where c=0 is the lower carrier, c=1 the master and c=2 the upper. The master increment is (code+1)·2^(W−11) when the code is nonzero, and 0 when the code is 0.
- R8: When the side enable is on and the code is nonzero, the upper increment is (code+2)·2^(W−11). The lower increment is code·2^(W−11) if the code is 2 or more, and 0 if the code is 1. With the side enable off, both side increments are 0.
- R9: Two channels with nonzero codes a and b conflict when |a−b| < 1 + sa + sb, where sa and sb are their side enables (0 or 1).
- R10: After a scan, `conflict` is 1 if any pair conflicts. `conflict_ch` then gives the lowest channel index that belongs to a conflicting pair. The result holds until the next scan ends.
- R11: Each accepted code or enable write makes `scan_busy` high on the next clock edge and restarts the scan. `scan_busy` falls within 153 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 pointer, 1 code, 2 side enable, 3 none |
| wr_data | input | 8 | Write value |
| sel_ptr | output | 6 | Current pointer |
| sel_code | output | 7 | Code of the pointed channel |
| sel_side | output | 1 | Side enable of the pointed channel |
| code_err | output | 1 | Sticky illegal-code flag |
| scan_busy | output | 1 | Conflict scan in progress |
| conflict | output | 1 | Last scan found a conflict |
| conflict_ch | output | 5 | Lowest conflicting channel index |
| carrier_inc | output | 1296 | 54 packed phase increments, 24 bits each |

## Verification
If the stored code or enable goes wrong, the fault appears in `carrier_inc` and in the pointer readback on the first sampling point after the write. The bench reads it there. A wrong pair order or a wrong spacing rule shows up only when a scan completes. The bench therefore waits for `scan_busy` to fall and then compares `conflict` and `conflict_ch` with values worked out from the spacing rule. These include the exact-spacing boundary and a case with mixed side enables. The bench also counts the scan length, so an early or late scan end is caught at the 153-cycle limit.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_CODE = 2'd1,
        SEL_SIDE = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    // Reference divider exponent: one code step is f_ref / 2^REF_DIV_LOG2
    localparam int REF_DIV_LOG2 = 11;
endpackage

// File: rtl/cfb_regs.sv
module cfb_regs
    import cfb_pkg::*;
#(
    parameter int NUM_CH   = 18,
    parameter int CODE_W   = 7,
    parameter int MAX_CODE = 101,
    parameter int PTR_W    = 6,
    parameter int PTR_MAX  = 53,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_sel,
    input  logic [7:0]                     wr_data,
    output logic [PTR_W-1:0]               ptr_o,
    output logic [NUM_CH-1:0][CODE_W-1:0]  codes_o,
    output logic [NUM_CH-1:0]              side_o,
    output logic                           err_o,
    output logic                           start_o
);
    typedef struct packed {
        logic [PTR_W-1:0]              ptr;
        logic [NUM_CH-1:0][CODE_W-1:0] code;
        logic [NUM_CH-1:0]             side;
        logic                          err;
    } regs_t;

    regs_t r_d, r_q;
    logic  ch_ok, code_legal, ptr_legal;
    logic [CH_W-1:0] ch_idx;

    always_comb begin
        r_d        = r_q;
        start_o    = 1'b0;
        ch_ok      = (r_q.ptr < PTR_W'(NUM_CH));
        ch_idx     = r_q.ptr[CH_W-1:0];
        code_legal = (wr_data <= 8'(MAX_CODE));
        ptr_legal  = (wr_data <= 8'(PTR_MAX));
        if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_PTR: begin
                    if (ptr_legal) r_d.ptr = wr_data[PTR_W-1:0];
                end
                SEL_CODE: begin
                    if (!code_legal) begin
                        r_d.err = 1'b1;
                    end else if (ch_ok) begin
                        r_d.code[ch_idx] = wr_data[CODE_W-1:0];
                        start_o          = 1'b1;
                    end
                end
                SEL_SIDE: begin
                    if (ch_ok) begin
                        r_d.side[ch_idx] = wr_data[0];
                        start_o          = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ptr_o   = r_q.ptr;
    assign codes_o = r_q.code;
    assign side_o  = r_q.side;
    assign err_o   = r_q.err;

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

    // R4
    bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CODE && wr_data > 8'(MAX_CODE)) |=> ($stable(r_q.code) && r_q.err));

    // R2
    bad_ptr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PTR && wr_data > 8'(PTR_MAX)) |=> $stable(r_q.ptr));
endmodule

// File: rtl/cfb_pair_scan.sv
module cfb_pair_scan #(
    parameter int NUM_CH = 18,
    parameter int CODE_W = 7,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [NUM_CH-1:0][CODE_W-1:0] codes,
    input  logic [NUM_CH-1:0]             side,
    output logic                          busy_o,
    output logic                          hit_o,
    output logic [CH_W-1:0]               hit_ch_o
);
    typedef struct packed {
        logic            busy;
        logic [CH_W-1:0] i;
        logic [CH_W-1:0] j;
        logic            hit;
        logic [CH_W-1:0] hit_ch;
    } scan_t;

    scan_t s_d, s_q;
    logic [CODE_W-1:0] ca, cb, diff;
    logic [2:0]        need;
    logic              clash, last_pair;

    always_comb begin
        s_d       = s_q;
        ca        = codes[s_q.i];
        cb        = codes[s_q.j];
        diff      = (ca > cb) ? (ca - cb) : (cb - ca);
        need      = 3'd1 + {2'b00, side[s_q.i]} + {2'b00, side[s_q.j]};
        clash     = (ca != '0) && (cb != '0) && (diff < CODE_W'(need));
        last_pair = (s_q.i == CH_W'(NUM_CH - 2)) && (s_q.j == CH_W'(NUM_CH - 1));
        if (start) begin
            s_d.busy = 1'b1;
            s_d.i    = '0;
            s_d.j    = CH_W'(1);
        end else if (s_q.busy) begin
            if (clash) begin
                s_d.busy   = 1'b0;
                s_d.hit    = 1'b1;
                s_d.hit_ch = s_q.i;
            end else if (last_pair) begin
                s_d.busy = 1'b0;
                s_d.hit  = 1'b0;
            end else if (s_q.j == CH_W'(NUM_CH - 1)) begin
                s_d.i = s_q.i + CH_W'(1);
                s_d.j = s_q.i + CH_W'(2);
            end else begin
                s_d.j = s_q.j + CH_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o   = s_q.busy;
    assign hit_o    = s_q.hit;
    assign hit_ch_o = s_q.hit_ch;

    // R11
    scan_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> s_q.busy);

    // R10
    result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !start) |=> ($stable(s_q.hit) && $stable(s_q.hit_ch)));

    // R10
    hit_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hit |-> (s_q.hit_ch < CH_W'(NUM_CH - 1)));

    // R11
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.i < s_q.j));
endmodule

// File: rtl/cfb_inc_gen.sv
module cfb_inc_gen
    import cfb_pkg::*;
#(
    parameter int NUM_CH  = 18,
    parameter int CODE_W  = 7,
    parameter int PHASE_W = 24,
    localparam int SH     = PHASE_W - REF_DIV_LOG2,
    localparam int NUM_CAR = NUM_CH * 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0][CODE_W-1:0] codes,
    input  logic [NUM_CH-1:0]             side,
    output logic [NUM_CAR*PHASE_W-1:0]    inc_o
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [PHASE_W-1:0] base, lo, mid, hi;
        logic               on, side_on;

        always_comb begin
            base    = PHASE_W'(codes[n]);
            on      = (codes[n] != '0);
            side_on = on && side[n];
            mid     = on ? ((base + PHASE_W'(1)) << SH) : '0;
            hi      = side_on ? ((base + PHASE_W'(2)) << SH) : '0;
            lo      = (side_on && codes[n] > CODE_W'(1)) ? (base << SH) : '0;
        end

        assign inc_o[(3*n+0)*PHASE_W +: PHASE_W] = lo;
        assign inc_o[(3*n+1)*PHASE_W +: PHASE_W] = mid;
        assign inc_o[(3*n+2)*PHASE_W +: PHASE_W] = hi;

        // R8
        side_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lo != '0) |-> (hi > mid && mid > lo));
    end
endmodule

// File: rtl/carrier_freq_bank.sv
module carrier_freq_bank #(
    parameter int NUM_CH   = 18,
    parameter int CODE_W   = 7,
    parameter int MAX_CODE = 101,
    parameter int PTR_W    = 6,
    parameter int PTR_MAX  = 53,
    parameter int PHASE_W  = 24,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int NUM_CAR = NUM_CH * 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [7:0]                 wr_data,
    output logic [PTR_W-1:0]           sel_ptr,
    output logic [CODE_W-1:0]          sel_code,
    output logic                       sel_side,
    output logic                       code_err,
    output logic                       scan_busy,
    output logic                       conflict,
    output logic [CH_W-1:0]            conflict_ch,
    output logic [NUM_CAR*PHASE_W-1:0] carrier_inc
);
    logic [NUM_CH-1:0][CODE_W-1:0] codes;
    logic [NUM_CH-1:0]             side;
    logic                          start;

    cfb_regs #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
        .PTR_W(PTR_W), .PTR_MAX(PTR_MAX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ptr_o(sel_ptr), .codes_o(codes), .side_o(side), .err_o(code_err), .start_o(start)
    );

    cfb_pair_scan #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .codes(codes), .side(side),
        .busy_o(scan_busy), .hit_o(conflict), .hit_ch_o(conflict_ch)
    );

    cfb_inc_gen #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .PHASE_W(PHASE_W)) u_inc (
        .clk(clk), .rst_n(rst_n), .codes(codes), .side(side), .inc_o(carrier_inc)
    );

    always_comb begin
        if (sel_ptr < PTR_W'(NUM_CH)) begin
            sel_code = codes[sel_ptr[CH_W-1:0]];
            sel_side = side[sel_ptr[CH_W-1:0]];
        end else begin
            sel_code = '0;
            sel_side = 1'b0;
        end
    end
endmodule

// File: tb/carrier_freq_bank_test.sv
module carrier_freq_bank_test;
    localparam int W  = 24;
    localparam int SH = W - 11;
    localparam int MAX_SCAN = 153;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [5:0] sel_ptr;
    logic [6:0] sel_code;
    logic sel_side, code_err, scan_busy, conflict;
    logic [4:0] conflict_ch;
    logic [54*W-1:0] carrier_inc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    carrier_freq_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sel_ptr(sel_ptr), .sel_code(sel_code), .sel_side(sel_side), .code_err(code_err),
        .scan_busy(scan_busy), .conflict(conflict), .conflict_ch(conflict_ch),
        .carrier_inc(carrier_inc)
    );

    // {sel, data, exp_ptr, exp_code, exp_side, exp_err}
    localparam logic [24:0] VEC [14] = '{
        {2'd0, 8'd5,   6'd5,  7'd0,   1'b0, 1'b0},  // R2
        {2'd1, 8'd40,  6'd5,  7'd40,  1'b0, 1'b0},  // R3
        {2'd2, 8'd1,   6'd5,  7'd40,  1'b1, 1'b0},  // R6
        {2'd0, 8'd60,  6'd5,  7'd40,  1'b1, 1'b0},  // R2 ignored
        {2'd1, 8'd102, 6'd5,  7'd40,  1'b1, 1'b1},  // R4
        {2'd0, 8'd17,  6'd17, 7'd0,   1'b0, 1'b1},  // R2
        {2'd1, 8'd101, 6'd17, 7'd101, 1'b0, 1'b1},  // R3 top code
        {2'd0, 8'd20,  6'd20, 7'd0,   1'b0, 1'b1},  // R3 readback 0
        {2'd1, 8'd7,   6'd20, 7'd0,   1'b0, 1'b1},  // R5
        {2'd2, 8'd1,   6'd20, 7'd0,   1'b0, 1'b1},  // R5
        {2'd0, 8'd5,   6'd5,  7'd40,  1'b1, 1'b1},  // R5 ch5 intact
        {2'd0, 8'd17,  6'd17, 7'd101, 1'b0, 1'b1},  // R5 ch17 intact
        {2'd3, 8'd0,   6'd17, 7'd101, 1'b0, 1'b1},  // R3 no-op select
        {2'd0, 8'd53,  6'd53, 7'd0,   1'b0, 1'b1}   // R2 top pointer
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // accepted code or side write, then wait for the scan
    task automatic wr_scan(input logic [1:0] s, input logic [7:0] d);
        int n;
        wr(s, d);
        chk(scan_busy == 1'b1, "R11", "busy after write", 64'(scan_busy), 64'd1);
        n = 0;
        while (scan_busy && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(n <= MAX_SCAN, "R11", "scan length", 64'(n), 64'(MAX_SCAN));
    endtask

    function automatic logic [W-1:0] inc_of(input int ch, input int k);
        return carrier_inc[(ch*3+k)*W +: W];
    endfunction

    task automatic chk_inc(input int ch, input logic [W-1:0] lo, input logic [W-1:0] mid,
                           input logic [W-1:0] hi, input string req);
        chk(inc_of(ch, 0) == lo,  req, "lower inc",  64'(inc_of(ch, 0)), 64'(lo));
        chk(inc_of(ch, 1) == mid, req, "master inc", 64'(inc_of(ch, 1)), 64'(mid));
        chk(inc_of(ch, 2) == hi,  req, "upper inc",  64'(inc_of(ch, 2)), 64'(hi));
    endtask

    task automatic chk_conf(input logic exp_hit, input logic [4:0] exp_ch, input string what);
        chk(conflict == exp_hit, "R9", what, 64'(conflict), 64'(exp_hit));
        if (exp_hit)
            chk(conflict_ch == exp_ch, "R10", what, 64'(conflict_ch), 64'(exp_ch));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(sel_ptr == 0 && sel_code == 0 && sel_side == 0, "R1", "pointer/code/side",
            64'({sel_ptr, sel_code, sel_side}), 64'd0);
        chk(code_err == 0 && scan_busy == 0 && conflict == 0, "R1", "err/busy/conflict",
            64'({code_err, scan_busy, conflict}), 64'd0);
        chk(carrier_inc == '0, "R1", "increments zero", 64'(carrier_inc != '0), 64'd0);

        // table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < 14; k++) begin
            wr(VEC[k][24:23], VEC[k][22:15]);
            chk({sel_ptr, sel_code, sel_side, code_err} == VEC[k][14:0],
                "R2/R3/R4/R5/R6", $sformatf("vector %0d", k),
                64'({sel_ptr, sel_code, sel_side, code_err}), 64'(VEC[k][14:0]));
        end
        while (scan_busy) @(negedge clk);
        chk(code_err == 1'b1, "R4", "sticky after legal writes", 64'(code_err), 64'd1);
        do_reset();
        chk(code_err == 1'b0, "R4", "cleared by reset", 64'(code_err), 64'd0);

        // increments: R7 R8
        wr(2'd0, 8'd2); wr_scan(2'd1, 8'd30); wr_scan(2'd2, 8'd1);
        chk_inc(2, W'(30) << SH, W'(31) << SH, W'(32) << SH, "R8");
        wr(2'd0, 8'd4); wr_scan(2'd1, 8'd1); wr_scan(2'd2, 8'd1);
        chk_inc(4, '0, W'(2) << SH, W'(3) << SH, "R8");
        wr(2'd0, 8'd6); wr_scan(2'd1, 8'd101);
        chk_inc(6, '0, W'(102) << SH, '0, "R7");
        wr_scan(2'd2, 8'd1);
        chk_inc(6, W'(101) << SH, W'(102) << SH, W'(103) << SH, "R8");
        wr(2'd0, 8'd7); wr_scan(2'd2, 8'd1);
        chk_inc(7, '0, '0, '0, "R7");
        chk_inc(3, '0, '0, '0, "R7");
        wr(2'd0, 8'd2); wr_scan(2'd1, 8'd0);
        chk_inc(2, '0, '0, '0, "R7");
        chk_conf(1'b0, 5'd0, "spread channels");

        // conflict rule and lowest index: R9 R10
        do_reset();
        wr(2'd0, 8'd0); wr_scan(2'd1, 8'd10);
        wr(2'd0, 8'd1); wr_scan(2'd1, 8'd11);
        chk_conf(1'b0, 5'd0, "adjacent masters, no sides");
        wr_scan(2'd2, 8'd1);
        chk_conf(1'b1, 5'd0, "one side enabled");
        wr(2'd0, 8'd0); wr_scan(2'd1, 8'd20);
        chk_conf(1'b0, 5'd0, "moved apart");
        wr(2'd0, 8'd5); wr_scan(2'd1, 8'd12);
        chk_conf(1'b1, 5'd1, "ch1 vs ch5");
        wr(2'd0, 8'd17); wr_scan(2'd1, 8'd20);
        chk_conf(1'b1, 5'd0, "ch0 vs ch17 same code");

        // exact spacing boundary: R9
        do_reset();
        wr(2'd0, 8'd2); wr_scan(2'd1, 8'd30); wr_scan(2'd2, 8'd1);
        wr(2'd0, 8'd9); wr_scan(2'd1, 8'd33); wr_scan(2'd2, 8'd1);
        chk_conf(1'b0, 5'd0, "three apart both sides");
        wr_scan(2'd1, 8'd32);
        chk_conf(1'b1, 5'd2, "two apart both sides");
        wr_scan(2'd2, 8'd0);
        chk_conf(1'b0, 5'd0, "two apart one side");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule